// File: doc/BRIEF.md
# Pooled Priority Bus Arbiter

This block picks one winner among up to `N` bus masters that compete for a single slave port. Each master has a programmable priority field, and the value of that field places the master in a priority pool. Larger values rank higher. When several pools hold requesters, the highest one wins. The top pool and the bottom pool (value 0) share access in rotation. The pools in between use a fixed order in which the lowest index wins.

One fairness rule applies on top of the pools. When two or more masters request, the master granted in the previous round is left out, whatever its priority. A master can therefore hold the slave for consecutive rounds only while no other master is asking.

An arbitration round runs on each clock edge at which `arbEn` is high. The result is registered. It appears on `grant` (one-hot) and `grantIdx` in the following cycle and stays there until the next round.

Top module: `pool_arbiter`

## Requirements
- R1: `grant` is one-hot or all zeros; bit i stands for master i. When a bit is set, `grantIdx` is its index. When `grant` is zero, `grantIdx` is 0.
- R2: The master's priority sits at bits [PRIO_W*i+PRIO_W-1 : PRIO_W*i] of `prio`. Among the eligible requesters, the winner is always taken from the highest priority value present.
- R3: In the top pool (all priority bits 1) and in the bottom pool (value 0), each pool keeps a pointer to its last winner. The search starts at the next index up, wraps around, and the pointer moves only when that pool wins. After reset both searches start at master 0.
- R4: In the intermediate pools (values between 0 and the top value), the lowest-indexed eligible requester wins.
- R5: After reset `grant` is zero and `grantIdx` is 0. With every priority at 0, requesters are granted in pure rotation 0,1,2,...
- R6: With two or more requests present, the most recently granted master is not granted.
- R7: A sole requester is granted in every round, including back-to-back rounds.
- R8: A round takes place only on a clock edge with `arbEn` high, and its result shows one cycle later. With `arbEn` low, `grant`, `grantIdx` and all internal pointers hold.
- R9: In a round with no request, `grant` becomes zero and `grantIdx` 0. The pool pointers and the remembered last winner keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arbEn | input | 1 | Run an arbitration round at this edge |
| req | input | N | Request per master |
| prio | input | N*PRIO_W | Packed priority fields, field i for master i |
| grant | output | N | One-hot grant, registered |
| grantIdx | output | $clog2(N) | Index of the granted master |

## Verification
The bench builds the arbiter with its defaults, four masters and 2-bit priority fields. With these values there are two rotating pools (3 and 0) and two fixed pools (1 and 2), and each pool can hold several competing masters. Directed sequences cover rotation inside each rotating pool, lowest-index order in the middle pools, the exclusion of the last winner against a higher-priority request, sole-requester repeats, stalled rounds and empty rounds. A long random stretch of requests, priorities and enables then reaches mixed pools and empty intermediate levels.

// File: rtl/pool_arb_pkg.sv
package pool_arb_pkg;
  // Strobes issued by control toward the datapath each cycle
  typedef struct packed {
    logic capture;      // register this cycle's winner
    logic excludeLast;  // mask out the previous winner (contention)
  } arbStrobe_t;
endpackage

// File: rtl/pool_arb_rr_pick.sv
module pool_arb_rr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] lastPtr,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  // Rotating search: first candidate strictly after lastPtr, wrapping
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      int pos;
      pos = (int'(lastPtr) + k) % N;
      if (!found && cand[pos]) begin
        found = 1'b1;
        pick  = IDX_W'(pos);
      end
    end
  end
endmodule

// File: rtl/pool_arb_datapath.sv
module pool_arb_datapath
  import pool_arb_pkg::*;
#(
  parameter int N      = 4,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic [N-1:0]      req,
  input  logic [N*PRIO_W-1:0] prio,
  input  logic [IDX_W-1:0]  lastIdx,
  input  logic [IDX_W-1:0]  ptrHi,
  input  logic [IDX_W-1:0]  ptrLo,
  output logic              winValid,
  output logic [IDX_W-1:0]  winIdx,
  output logic [PRIO_W-1:0] winLvl,
  output logic [N-1:0]      grant,
  output logic [IDX_W-1:0]  grantIdx
);
  localparam logic [PRIO_W-1:0] MAX_LVL = '1;

  logic [PRIO_W-1:0] lvl [N];
  logic [N-1:0]      exclMask, elig, poolMask;
  logic [PRIO_W-1:0] topLvl;
  logic              anyElig;
  logic [IDX_W-1:0]  fixPick, hiPick, loPick;
  logic              hiFound, loFound;

  for (genvar i = 0; i < N; i++) begin : g_lvl
    assign lvl[i] = prio[i*PRIO_W +: PRIO_W];
  end

  // Contention exclusion of the previous winner
  always_comb begin
    exclMask = '0;
    if (strobe.excludeLast) exclMask[lastIdx] = 1'b1;
    elig = req & ~exclMask;
  end

  // Highest populated level among eligible requesters
  always_comb begin
    topLvl  = '0;
    anyElig = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (elig[i]) begin
        anyElig = 1'b1;
        if (lvl[i] > topLvl) topLvl = lvl[i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pool
    assign poolMask[i] = elig[i] && (lvl[i] == topLvl);
  end

  // Fixed order for middle pools: lowest index wins
  always_comb begin
    fixPick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (poolMask[i]) fixPick = IDX_W'(i);
    end
  end

  pool_arb_rr_pick #(.N(N), .IDX_W(IDX_W)) hiPick_i (
    .cand(poolMask), .lastPtr(ptrHi), .found(hiFound), .pick(hiPick)
  );
  pool_arb_rr_pick #(.N(N), .IDX_W(IDX_W)) loPick_i (
    .cand(poolMask), .lastPtr(ptrLo), .found(loFound), .pick(loPick)
  );

  always_comb begin
    winValid = anyElig;
    winLvl   = topLvl;
    if (topLvl == MAX_LVL && hiFound)   winIdx = hiPick;
    else if (topLvl == '0 && loFound)   winIdx = loPick;
    else                                winIdx = fixPick;
  end

  // Registered grant stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant    <= '0;
      grantIdx <= '0;
    end else if (strobe.capture) begin
      if (winValid) begin
        grant    <= N'(1) << winIdx;
        grantIdx <= winIdx;
      end else begin
        grant    <= '0;
        grantIdx <= '0;
      end
    end
  end
endmodule

// File: rtl/pool_arb_control.sv
module pool_arb_control
  import pool_arb_pkg::*;
#(
  parameter int N      = 4,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arbEn,
  input  logic [N-1:0]      req,
  input  logic              winValid,
  input  logic [IDX_W-1:0]  winIdx,
  input  logic [PRIO_W-1:0] winLvl,
  output arbStrobe_t        strobe,
  output logic [IDX_W-1:0]  lastIdx,
  output logic [IDX_W-1:0]  ptrHi,
  output logic [IDX_W-1:0]  ptrLo
);
  localparam logic [PRIO_W-1:0] MAX_LVL  = '1;
  localparam logic [IDX_W-1:0]  PTR_INIT = IDX_W'(N - 1);

  logic lastValid;
  logic multiReq;

  always_comb begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < N; i++) cnt += int'(req[i]);
    multiReq = (cnt > 1);
  end

  always_comb begin
    strobe.capture     = arbEn;
    strobe.excludeLast = lastValid && multiReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastIdx   <= '0;
      lastValid <= 1'b0;
      ptrHi     <= PTR_INIT;
      ptrLo     <= PTR_INIT;
    end else if (arbEn && winValid) begin
      lastIdx   <= winIdx;
      lastValid <= 1'b1;
      if (winLvl == MAX_LVL) ptrHi <= winIdx;
      if (winLvl == '0)      ptrLo <= winIdx;
    end
  end
endmodule

// File: rtl/pool_arbiter.sv
module pool_arbiter
  import pool_arb_pkg::*;
#(
  parameter int N      = 4,
  parameter int PRIO_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  arbEn,
  input  logic [N-1:0]          req,
  input  logic [N*PRIO_W-1:0]   prio,
  output logic [N-1:0]          grant,
  output logic [$clog2(N)-1:0]  grantIdx
);
  localparam int IDX_W = $clog2(N);

  arbStrobe_t        strobe;
  logic [IDX_W-1:0]  lastIdx, ptrHi, ptrLo, winIdx;
  logic              winValid;
  logic [PRIO_W-1:0] winLvl;

  pool_arb_control #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .arbEn(arbEn), .req(req),
    .winValid(winValid), .winIdx(winIdx), .winLvl(winLvl),
    .strobe(strobe), .lastIdx(lastIdx), .ptrHi(ptrHi), .ptrLo(ptrLo)
  );

  pool_arb_datapath #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .req(req), .prio(prio),
    .lastIdx(lastIdx), .ptrHi(ptrHi), .ptrLo(ptrLo),
    .winValid(winValid), .winIdx(winIdx), .winLvl(winLvl),
    .grant(grant), .grantIdx(grantIdx)
  );
endmodule

// File: rtl/pool_arbiter_chk.sv
module pool_arbiter_chk #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             arbEn,
  input logic [N-1:0]     req,
  input logic [N-1:0]     grant,
  input logic [IDX_W-1:0] grantIdx
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R1

  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0) |-> (grant == (N'(1) << grantIdx))); // R1

  AST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (grant == '0) |-> (grantIdx == '0)); // R1

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rstN)
    !arbEn |=> ($stable(grant) && $stable(grantIdx))); // R8

  AST_EMPTY_ROUND: assert property (@(posedge clk) disable iff (!rstN)
    (arbEn && req == '0) |=> (grant == '0)); // R9

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    (arbEn && $countones(req) > 1 && grant != '0) |=> (grant != $past(grant))); // R6

  AST_SOLE_WIN: assert property (@(posedge clk) disable iff (!rstN)
    (arbEn && $countones(req) == 1) |=> (grant == $past(req))); // R7

  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    (arbEn && req != '0) |=> ((grant & $past(req)) == grant && grant != '0)); // R2
endmodule

bind pool_arbiter pool_arbiter_chk #(.N(N), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rstN(rstN), .arbEn(arbEn), .req(req),
  .grant(grant), .grantIdx(grantIdx)
);

// File: tb/pool_arbiter_tb_top.sv
module pool_arbiter_tb_top;
  localparam int N  = 4;
  localparam int PW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic           rstN = 1'b0;
  logic           arbEn = 1'b0;
  logic [N-1:0]   req = '0;
  logic [N*PW-1:0] prio = '0;
  logic [N-1:0]   grant;
  logic [IW-1:0]  grantIdx;

  pool_arbiter #(.N(N), .PRIO_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .arbEn(arbEn), .req(req), .prio(prio),
    .grant(grant), .grantIdx(grantIdx)
  );

  typedef struct {
    logic [N-1:0]  g;
    logic [IW-1:0] idx;
    string         tag;
  } exp_t;
  exp_t q[$];

  int runCnt = 0;
  int failCnt = 0;

  // Requirement-level model state
  int           mLast = 0;
  bit           mLastV = 0;
  int           mPtr[2] = '{N-1, N-1};
  logic [N-1:0] mG = '0;
  int           mIdx = 0;

  function automatic logic [N*PW-1:0] pk(int a0, int a1, int a2, int a3);
    logic [PW-1:0] b0, b1, b2, b3;
    b0 = PW'(a0); b1 = PW'(a1); b2 = PW'(a2); b3 = PW'(a3);
    return {b3, b2, b1, b0};
  endfunction

  function automatic void modelStep(logic [N-1:0] r, logic [N*PW-1:0] p);
    int cnt, top, win, pool;
    logic [N-1:0] e;
    int lv[N];
    cnt = 0;
    for (int i = 0; i < N; i++) begin
      cnt += int'(r[i]);
      lv[i] = int'(p[i*PW +: PW]);
    end
    e = r;
    if (mLastV && cnt > 1) e[mLast] = 1'b0;
    if (e == '0) begin
      mG = '0; mIdx = 0;
      return;
    end
    top = -1;
    for (int i = 0; i < N; i++) if (e[i] && lv[i] > top) top = lv[i];
    win = -1;
    if (top == (1 << PW) - 1 || top == 0) begin
      pool = (top == 0) ? 0 : 1;
      for (int k = 1; k <= N; k++) begin
        int c;
        c = (mPtr[pool] + k) % N;
        if (win < 0 && e[c] && lv[c] == top) win = c;
      end
      mPtr[pool] = win;
    end else begin
      for (int i = N - 1; i >= 0; i--) if (e[i] && lv[i] == top) win = i;
    end
    mG = N'(1) << win;
    mIdx = win;
    mLast = win;
    mLastV = 1;
  endfunction

  task automatic drive(logic en, logic [N-1:0] r, logic [N*PW-1:0] p, string tag);
    exp_t e;
    @(negedge clk);
    arbEn = en; req = r; prio = p;
    if (en) modelStep(r, p);
    e.g = mG; e.idx = IW'(mIdx); e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare after each capturing edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      runCnt++;
      if (grant !== e.g || grantIdx !== e.idx) begin
        failCnt++;
        $display("FAIL %s: grant=%b idx=%0d expected grant=%b idx=%0d",
                 e.tag, grant, grantIdx, e.g, e.idx);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    runCnt++;
    if (grant !== '0 || grantIdx !== '0) begin
      failCnt++;
      $display("FAIL R5 reset: grant=%b idx=%0d expected grant=0000 idx=0", grant, grantIdx);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R5 R3: pure rotation at level 0
    for (int i = 0; i < 6; i++) drive(1'b1, 4'b1111, pk(0,0,0,0), "R5 R3 rotation lvl0");
    // R7: sole requester back to back
    for (int i = 0; i < 3; i++) drive(1'b1, 4'b0100, pk(0,0,0,0), "R7 sole requester");
    // R2 R6: top-pool master vs bottom pool, exclusion
    for (int i = 0; i < 5; i++) drive(1'b1, 4'b1111, pk(0,0,3,0), "R2 R6 top pool vs low");
    // R4: intermediate fixed order
    for (int i = 0; i < 5; i++) drive(1'b1, 4'b1111, pk(1,2,1,2), "R4 middle pools fixed");
    drive(1'b1, 4'b0101, pk(1,0,1,0), "R4 middle pool lowest index");
    // R3: top pool rotation with two members
    for (int i = 0; i < 5; i++) drive(1'b1, 4'b1111, pk(0,3,0,3), "R3 rotation top pool");
    // R8: stall holds outputs
    for (int i = 0; i < 3; i++) drive(1'b0, 4'b0011, pk(3,0,0,0), "R8 stall holds");
    drive(1'b1, 4'b0011, pk(3,0,0,0), "R8 round after stall");
    // R9: empty round then rotation resumes from kept pointers
    drive(1'b1, 4'b0000, pk(0,0,0,0), "R9 empty round");
    drive(1'b0, 4'b1111, pk(0,0,0,0), "R9 R8 hold zero");
    for (int i = 0; i < 4; i++) drive(1'b1, 4'b1111, pk(0,0,0,0), "R9 pointers kept");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic en;
      en = ($urandom % 5) != 0;
      drive(en, N'($urandom), (N*PW)'($urandom), "R1 R2 R3 R4 R6 random");
    end
    @(negedge clk);
    arbEn = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule